// File: doc/BRIEF.md
# Up/Down Counter Pulse-Width Modulator

This block turns a stored duty word into a single-bit pulse train whose high time, measured in clock cycles, equals the word. It has no free-running compare counter. One reloadable counter runs in two phases. In the mark phase the counter counts down from the duty value. In the space phase it counts up from the duty value to full scale. A phase flip-flop toggles at each terminal count and sets the counting direction. The counter is reloaded from the duty register every time the phase changes.

A write strobe stores a new duty word at any moment. The counter only picks up the new word at its next reload, so a running mark or space interval always finishes with its old length. The frame is 2^W clock cycles long. With the default width of 16 and a 4 MHz clock, one count is 250 ns, and a word of 0x8000 gives a 50% duty cycle, 0xC000 gives 75%, 0x4000 gives 25% and 0xE600 gives 90%.

Top module: `pwm_updown_gen`

## Requirements
- R1: In the first cycle after a synchronous reset, pwm_o is low, the stored duty word is zero and term_o is high, so the counter reloads at once. With no write after reset, pwm_o stays low.
- R2: A cycle with wr_en high stores wr_data as the duty word. The stored word is used from the next terminal-count reload onward.
- R3: For a duty word D of 1 or more, every frame holds exactly D consecutive cycles with pwm_o high. The counter is reloaded with D at each terminal count.
- R4: For D of 1 or more, successive rising edges of pwm_o are exactly 2^W cycles apart.
- R5: term_o is high for exactly two cycles in each frame, one at the end of the mark phase and one at the end of the space phase, and the phase flips in the cycle after each of these.
- R6: In the mark phase the counter moves down by one per cycle. In the space phase it moves up by one per cycle until it reaches all-ones.
- R7: A write that arrives during a mark interval does not shorten that interval. The following space interval lasts 2^W minus the new word, and the mark after that lasts the new word.
- R8: A duty word of zero keeps pwm_o low for as long as it is stored.
- R9: The all-ones duty word gives 2^W-1 high cycles and one low cycle per frame.
- R10: pwm_o comes from a register, and it is high only while the phase is the mark (down-counting) phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the duty word |
| wr_data | input | W | New duty word |
| pwm_o | output | 1 | Registered pulse-width-modulated output |
| term_o | output | 1 | Terminal-count flag, high in the last cycle of each phase |

## Verification
The hardest case to reach from the ports is a duty write that lands partway through a mark interval. If the design were wrong here, it would cut the mark short or change the next space interval. To reach it, the bench locks onto a rising edge of pwm_o, counts ten cycles and then writes. It then measures the high run, the low run and the next high run against the old word and the new word. The extremes also need care, because each ends a phase after only one cycle. The bench writes zero and all-ones and then measures whole frames at those values. It also applies a reset in the middle of a mark interval.

// File: rtl/pwm_ud_pkg.sv
package pwm_ud_pkg;

    localparam int unsigned DEF_WIDTH = 16;

    // Phase of the modulator: mark counts down, space counts up.
    typedef enum logic {
        PH_MARK  = 1'b0,
        PH_SPACE = 1'b1
    } phase_e;

    // Registered state of the phase stage.
    typedef struct packed {
        phase_e phase;
        logic   level;
    } phase_state_t;

    function automatic phase_e flip_phase(input phase_e p);
        return (p == PH_MARK) ? PH_SPACE : PH_MARK;
    endfunction

endpackage

// File: rtl/pwm_duty_reg.sv
module pwm_duty_reg #(
    parameter int unsigned W = pwm_ud_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] duty_q
);

    always_ff @(posedge clk) begin
        if (rst)        duty_q <= '0;
        else if (wr_en) duty_q <= wr_data;
    end

    // R2: a strobe stores the presented word
    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> duty_q == $past(wr_data));

    // R2: without a strobe the word holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(duty_q));

endmodule

// File: rtl/pwm_ud_counter.sv
module pwm_ud_counter
    import pwm_ud_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_e       dir_i,
    input  logic         reload_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] count_next_o,
    output logic         term_o
);

    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q;
    logic [W-1:0] count_d;

    // The mark phase ends on count one, or at once when the word is zero,
    // so a mark lasts exactly D cycles. The space phase ends at full scale.
    always_comb begin
        if (dir_i == PH_SPACE) term_o = (count_q == FULL);
        else                   term_o = (count_q <= ONE);
    end

    always_comb begin
        if (rst)                   count_d = '0;
        else if (reload_i)         count_d = load_val_i;
        else if (dir_i == PH_MARK) count_d = count_q - ONE;
        else                       count_d = count_q + ONE;
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    assign count_o      = count_q;
    assign count_next_o = count_d;

    // R3: every reload takes the stored duty word
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> count_q == $past(load_val_i));

    // R6: a single down step per mark cycle
    p_down_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && dir_i == PH_MARK) |=> count_q == $past(count_q) - ONE);

    // R6: a single up step per space cycle
    p_up_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && dir_i == PH_SPACE) |=> count_q == $past(count_q) + ONE);

endmodule

// File: rtl/pwm_phase_tff.sv
module pwm_phase_tff
    import pwm_ud_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         term_i,
    input  logic [W-1:0] count_next_i,
    output phase_e       phase_o,
    output logic         level_o
);

    phase_state_t st_q;
    phase_state_t st_d;

    always_comb begin
        if (rst) begin
            st_d.phase = PH_MARK;
            st_d.level = 1'b0;
        end else begin
            st_d.phase = term_i ? flip_phase(st_q.phase) : st_q.phase;
            st_d.level = (st_d.phase == PH_MARK) && (count_next_i != '0);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign level_o = st_q.level;

    // R5: the phase flips after each terminal count
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        term_i |=> st_q.phase != $past(st_q.phase));

    // R5: the phase holds without a terminal count
    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !term_i |=> $stable(st_q.phase));

endmodule

// File: rtl/pwm_updown_gen.sv
module pwm_updown_gen
    import pwm_ud_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pwm_o,
    output logic         term_o
);

    logic [W-1:0] duty;
    logic [W-1:0] count;
    logic [W-1:0] count_next;
    logic         term;
    phase_e       phase;
    logic         level;

    pwm_duty_reg #(.W(W)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .duty_q  (duty)
    );

    pwm_ud_counter #(.W(W)) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .dir_i        (phase),
        .reload_i     (term),
        .load_val_i   (duty),
        .count_o      (count),
        .count_next_o (count_next),
        .term_o       (term)
    );

    pwm_phase_tff #(.W(W)) u_phase (
        .clk          (clk),
        .rst          (rst),
        .term_i       (term),
        .count_next_i (count_next),
        .phase_o      (phase),
        .level_o      (level)
    );

    assign pwm_o  = level;
    assign term_o = term;

    // R10: output high only in the mark phase
    p_mark_only_r10: assert property (@(posedge clk) disable iff (rst)
        pwm_o |-> phase == PH_MARK);

    // R8: a zero word in the space phase never leads to a high output
    p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SPACE && duty == '0 && !wr_en) |=> !pwm_o);

    // R1: counter and phase are cleared when reset has just been applied
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && phase == PH_MARK && !pwm_o));

endmodule

// File: tb/pwm_updown_gen_test.sv
module pwm_updown_gen_test;

    localparam int unsigned W     = 8;
    localparam int unsigned FRAME = 1 << W;

    typedef struct packed {
        logic [W-1:0] duty;
        logic [15:0]  mark;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{duty: 8'h80, mark: 16'd128},
        '{duty: 8'hC0, mark: 16'd192},
        '{duty: 8'h40, mark: 16'd64},
        '{duty: 8'hE6, mark: 16'd230},
        '{duty: 8'h19, mark: 16'd25},
        '{duty: 8'h01, mark: 16'd1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o;
    logic         term_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwm_updown_gen #(.W(W)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .term_o  (term_o)
    );

    always #4 clk = ~clk;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [W-1:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Leaves the bench at the first negedge where pwm_o is high after a low.
    task automatic sync_rise(output bit ok);
        int guard = 0;
        ok = 1'b0;
        @(negedge clk);
        while (pwm_o && guard < 4 * FRAME) begin
            @(negedge clk);
            guard++;
        end
        while (!pwm_o && guard < 4 * FRAME) begin
            @(negedge clk);
            guard++;
        end
        ok = pwm_o;
    endtask

    task automatic measure_frame(input int mark, input string tag);
        bit ok;
        int highs = 0;
        int run = 0;
        int terms = 0;
        bit in_run = 1'b1;
        bit last = 1'b0;
        sync_rise(ok);
        check_eq({tag, " R4 rising edge found"}, int'(ok), 1);
        for (int i = 0; i < int'(FRAME); i++) begin
            if (i > 0) @(negedge clk);
            highs += int'(pwm_o);
            terms += int'(term_o);
            if (in_run && pwm_o) run++;
            else in_run = 1'b0;
            if (i == int'(FRAME) - 1) last = pwm_o;
        end
        @(negedge clk);
        check_eq({tag, " R3 high cycles"}, highs, mark);
        check_eq({tag, " R3 contiguous mark"}, run, mark);
        check_eq({tag, " R4 low before next edge"}, int'(last), 0);
        check_eq({tag, " R4 next edge at frame"}, int'(pwm_o), 1);
        check_eq({tag, " R5 terminal counts"}, terms, 2);
    endtask

    task automatic run_length(input logic lvl, output int n);
        n = 0;
        while (pwm_o == lvl && n < 2 * int'(FRAME)) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int highs;
        bit ok;

        // R1: reset state and the immediate reload
        repeat (3) @(negedge clk);
        check_eq("R1 pwm low in reset", int'(pwm_o), 0);
        check_eq("R1 reload flag after reset", int'(term_o), 1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 flag clears after reload", int'(term_o), 0);
        highs = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
        check_eq("R1 R8 output low with cleared word", highs, 0);

        // R2 R3 R4 R5: table of duty words
        foreach (VEC[k]) begin
            write_word(VEC[k].duty);
            repeat (2 * FRAME + 4) @(negedge clk);
            measure_frame(int'(VEC[k].mark), $sformatf("vec%0d", k));
        end

        // R9: all-ones word
        write_word('1);
        repeat (2 * FRAME + 4) @(negedge clk);
        measure_frame(int'(FRAME) - 1, "R9 full scale");

        // R7: write landing mid-mark
        write_word(8'h40);
        repeat (2 * FRAME + 4) @(negedge clk);
        sync_rise(ok);
        check_eq("R7 sync", int'(ok), 1);
        repeat (9) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'h80;
        @(negedge clk);
        wr_en   = 1'b0;
        run_length(1'b1, n);
        check_eq("R7 current mark not cut", n + 10, 64);
        run_length(1'b0, n);
        check_eq("R7 space uses new word", n, int'(FRAME) - 128);
        run_length(1'b1, n);
        check_eq("R7 next mark uses new word", n, 128);

        // R8: zero word holds the output low
        write_word('0);
        repeat (2 * FRAME + 4) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 3 * int'(FRAME); i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
        check_eq("R8 zero word output low", highs, 0);

        // R1: reset in the middle of a mark clears the word
        write_word(8'h80);
        repeat (2 * FRAME + 4) @(negedge clk);
        sync_rise(ok);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 pwm low after reset edge", int'(pwm_o), 0);
        rst = 1'b0;
        highs = 0;
        for (int i = 0; i < 3 * int'(FRAME); i++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
        check_eq("R1 word cleared by reset", highs, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule